// File: doc/BRIEF.md
# Four-Channel Register Bank with Maskable Interrupts

This block holds the host-visible registers of a four-channel line interface device. A simple synchronous host bus (address, write data, read data, write strobe, read strobe) reaches one global register set and four copies of a per-channel set. The two address bits above the low byte pick the channel. Upper value 0 is shared: low bytes inside a parameterised global window go to the global set, and all others go to channel 0.

Every set holds four registers. Control is read-write and drives an output toward the rest of the device. Status is read-only and shows a live hardware input. Interrupt status is read-only: its bits capture hardware event pulses and hold them until the host reads the register. Mask is read-write, and a 1 in a mask bit blocks the matching interrupt status bit. One shared active-low interrupt line is asserted while any unblocked interrupt status bit is set in any set.

Register offsets inside a set are 0 control, 1 status, 2 interrupt status and 3 mask. The global set starts at low byte 0x00. Each channel set starts at low byte `CH_BASE` (default 0x20). The default global window is 0x00 to 0x0F.

Top module: `regbank_top`

## Requirements
- R1: After reset all control and mask registers are zero, all interrupt status bits are clear, `rdata` is zero and `irq_n` is high.
- R2: A write to a control (offset 0) or mask (offset 3) register stores `wdata`. A later read returns it. A control register's value appears on its control output from the cycle after the write.
- R3: A read of a status register (offset 1) returns that set's status input as sampled at the read clock edge. Writes to it have no effect.
- R4: A 1 on an event input bit sets the matching interrupt status bit at that clock edge. The bit stays set until its register is read.
- R5: A read of an interrupt status register (offset 2) returns its contents and clears it. Writes to it have no effect.
- R6: If an event arrives in the same cycle as a read of its interrupt status register, the read returns the value held before that edge, and the new event bit is left set.
- R7: `irq_n` is low exactly when some interrupt status bit is set while its mask bit is 0, in any channel or in the global set. A mask bit of 1 blocks its source.
- R8: Address bits [9:8] select channel 0..3 at low bytes `CH_BASE`+0..3. With bits [9:8] = 0, a low byte below `GLOBAL_SPAN` selects the global set at low bytes 0..3.
- R9: A read of an unmapped address returns 0. A write to an unmapped address changes no register.
- R10: `rdata` updates only at a clock edge where `rd_en` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Register address: bits [9:8] set, bits [7:0] offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| glb_status_in | input | 8 | Live status of the global set |
| glb_event_in | input | 8 | Event pulses of the global set |
| ch_status_in | input | 32 | Live status, channel n in bits [8n+7:8n] |
| ch_event_in | input | 32 | Event pulses, channel n in bits [8n+7:8n] |
| glb_ctrl_out | output | 8 | Global control register value |
| ch_ctrl_out | output | 32 | Channel control values, channel n in bits [8n+7:8n] |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Directed accesses cover the following cases:
- Writes that alias channel 0 against the global window, which show whether the decoder splits upper value 0 correctly.
- Writes to status, interrupt status and unmapped offsets, which show whether any of them leak into state.
- An event that meets a read of its own register in the same cycle, which separates a correct set-wins merge from a clear-wins merge.
- Mask toggling around a pending bit, which shows that the line tracks the mask.

Long random runs follow. They mix addresses near every set boundary, overlapping reads and writes, sparse event pulses and changing status values, and a reference model checks read data, control outputs and the interrupt line on every cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_STAT,
        RK_ISR,
        RK_MASK
    } reg_kind_e;

    localparam int SET_REGS = 4;

    function automatic reg_kind_e kind_of(input logic [1:0] off);
        unique case (off)
            2'd0:    return RK_CTRL;
            2'd1:    return RK_STAT;
            2'd2:    return RK_ISR;
            default: return RK_MASK;
        endcase
    endfunction

endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode
    import regbank_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int NUM_CH      = 4,
    parameter int GLOBAL_SPAN = 16,
    parameter int CH_BASE     = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              glb_hit,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_kind_e         kind
);
    localparam int UP_W = ADDR_W - 8;

    logic [UP_W-1:0] upper;
    logic [7:0]      low;
    logic [7:0]      off;
    logic            in_glb;
    logic            in_rng;
    logic            ch_ok;

    always_comb begin
        upper  = addr[ADDR_W-1:8];
        low    = addr[7:0];
        in_glb = (upper == '0) && (int'(low) < GLOBAL_SPAN);
        off    = in_glb ? low : (low - 8'(CH_BASE));
        in_rng = (int'(off) < SET_REGS);
        ch_ok  = (int'(upper) < NUM_CH);
        glb_hit = in_glb && in_rng;
        for (int i = 0; i < NUM_CH; i++) begin
            ch_hit[i] = !in_glb && in_rng && ch_ok && (int'(upper) == i);
        end
        if (glb_hit || (|ch_hit)) kind = kind_of(off[1:0]);
        else                      kind = RK_NONE;
    end

endmodule

// File: rtl/rb_reg_set.sv
module rb_reg_set
    import regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  reg_kind_e         kind,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] event_in,
    output logic [DATA_W-1:0] ctrl_out,
    output logic [DATA_W-1:0] rd_val,
    output logic              irq_req
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] isr_q;
    logic              wr_ctrl;
    logic              wr_mask;
    logic              rd_isr;

    assign wr_ctrl = sel && wr_en && (kind == RK_CTRL);
    assign wr_mask = sel && wr_en && (kind == RK_MASK);
    assign rd_isr  = sel && rd_en && (kind == RK_ISR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            isr_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_mask) mask_q <= wdata;
            isr_q <= (rd_isr ? '0 : isr_q) | event_in;
        end
    end

    always_comb begin
        rd_val = '0;
        if (sel) begin
            unique case (kind)
                RK_CTRL: rd_val = ctrl_q;
                RK_STAT: rd_val = status_in;
                RK_ISR:  rd_val = isr_q;
                RK_MASK: rd_val = mask_q;
                default: rd_val = '0;
            endcase
        end
    end

    assign ctrl_out = ctrl_q;
    assign irq_req  = |(isr_q & ~mask_q);

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q)); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q)); // R9
    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (event_in != '0) |=> ((isr_q & $past(event_in)) == $past(event_in))); // R6
    AST_ISR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_isr |=> ((isr_q & $past(isr_q)) == $past(isr_q))); // R4
    AST_ISR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr && event_in == '0) |=> (isr_q == '0)); // R5

endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int NUM_CH      = 4,
    parameter int GLOBAL_SPAN = 16,
    parameter int CH_BASE     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [DATA_W-1:0]        glb_status_in,
    input  logic [DATA_W-1:0]        glb_event_in,
    input  logic [NUM_CH*DATA_W-1:0] ch_status_in,
    input  logic [NUM_CH*DATA_W-1:0] ch_event_in,
    output logic [DATA_W-1:0]        glb_ctrl_out,
    output logic [NUM_CH*DATA_W-1:0] ch_ctrl_out,
    output logic                     irq_n
);
    localparam int NSETS = NUM_CH + 1;

    logic              glb_hit;
    logic [NUM_CH-1:0] ch_hit;
    reg_kind_e         kind;
    logic [DATA_W-1:0] rd_vals [NSETS];
    logic [NSETS-1:0]  irq_reqs;
    logic [DATA_W-1:0] rd_any;
    logic [DATA_W-1:0] rdata_q;

    rb_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
        .GLOBAL_SPAN(GLOBAL_SPAN), .CH_BASE(CH_BASE)
    ) u_dec (
        .addr(addr), .glb_hit(glb_hit), .ch_hit(ch_hit), .kind(kind)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            rb_reg_set #(.DATA_W(DATA_W)) u_set (
                .clk(clk), .rst_n(rst_n), .sel(ch_hit[c]), .kind(kind),
                .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
                .status_in(ch_status_in[c*DATA_W +: DATA_W]),
                .event_in(ch_event_in[c*DATA_W +: DATA_W]),
                .ctrl_out(ch_ctrl_out[c*DATA_W +: DATA_W]),
                .rd_val(rd_vals[c]), .irq_req(irq_reqs[c])
            );
        end
    endgenerate

    rb_reg_set #(.DATA_W(DATA_W)) u_glb (
        .clk(clk), .rst_n(rst_n), .sel(glb_hit), .kind(kind),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .status_in(glb_status_in), .event_in(glb_event_in),
        .ctrl_out(glb_ctrl_out),
        .rd_val(rd_vals[NUM_CH]), .irq_req(irq_reqs[NUM_CH])
    );

    always_comb begin
        rd_any = '0;
        for (int s = 0; s < NSETS; s++) rd_any = rd_any | rd_vals[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_any;
    end

    assign rdata = rdata_q;
    assign irq_n = ~(|irq_reqs);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10
    AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({glb_hit, ch_hit})); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(wr_en || (|glb_event_in) || (|ch_event_in))); // R7

endmodule

// File: tb/sim_regbank_top.sv
`timescale 1ns/1ps
module sim_regbank_top;
    localparam int AW = 10, DW = 8, NCH = 4, GSPAN = 16, CBASE = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wdata = '0, glb_st = '0, glb_ev = '0;
    logic [NCH*DW-1:0] ch_st = '0, ch_ev = '0;
    logic [DW-1:0] rdata, glb_ctrl;
    logic [NCH*DW-1:0] ch_ctrl;
    logic irq_n;

    int total = 0, bad = 0;
    bit done = 0;

    logic [DW-1:0] m_ctrl [NCH+1];
    logic [DW-1:0] m_mask [NCH+1];
    logic [DW-1:0] m_isr  [NCH+1];
    logic [DW-1:0] m_rdata;

    always #2 clk = ~clk;

    regbank_top u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .glb_status_in(glb_st),
        .glb_event_in(glb_ev), .ch_status_in(ch_st), .ch_event_in(ch_ev),
        .glb_ctrl_out(glb_ctrl), .ch_ctrl_out(ch_ctrl), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // set index NCH = global; kind 0 ctrl, 1 status, 2 interrupt status, 3 mask
    function automatic void decode(input logic [AW-1:0] a, output int s, output int k);
        int up = int'(a[AW-1:8]);
        int lo = int'(a[7:0]);
        s = -1; k = -1;
        if (up == 0 && lo < GSPAN) begin
            if (lo < 4) begin s = NCH; k = lo; end
        end else if (up < NCH && lo >= CBASE && lo < CBASE + 4) begin
            s = up; k = lo - CBASE;
        end
    endfunction

    function automatic logic [DW-1:0] stat_of(input int s);
        return (s == NCH) ? glb_st : ch_st[s*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] ev_of(input int s);
        return (s == NCH) ? glb_ev : ch_ev[s*DW +: DW];
    endfunction

    function automatic logic exp_irq_n();
        logic any = 1'b0;
        for (int i = 0; i <= NCH; i++) any |= |(m_isr[i] & ~m_mask[i]);
        return ~any;
    endfunction

    task automatic step();
        int s, k;
        logic [DW-1:0] v;
        string tag;
        decode(addr, s, k);
        v = '0;
        if (s >= 0) begin
            case (k)
                0: v = m_ctrl[s];
                1: v = stat_of(s);
                2: v = m_isr[s];
                default: v = m_mask[s];
            endcase
        end
        if (!rd_en) tag = "R10";
        else if (s < 0) tag = "R9";
        else if (k == 1) tag = "R3";
        else if (k == 2) tag = "R5";
        else tag = "R2";
        if (rd_en) m_rdata = v;
        if (wr_en && s >= 0) begin
            if (k == 0) m_ctrl[s] = wdata;
            if (k == 3) m_mask[s] = wdata;
        end
        for (int i = 0; i <= NCH; i++) begin
            if (rd_en && s == i && k == 2) m_isr[i] = '0;
            m_isr[i] = m_isr[i] | ev_of(i);
        end
        @(posedge clk);
        @(negedge clk);
        check(rdata == m_rdata, tag, "rdata", rdata, m_rdata);
        check(irq_n == exp_irq_n(), "R7", "irq_n", irq_n, exp_irq_n());
        check(glb_ctrl == m_ctrl[NCH], (wr_en && s < 0) ? "R9" : "R2",
              "glb_ctrl", glb_ctrl, m_ctrl[NCH]);
        for (int i = 0; i < NCH; i++)
            check(ch_ctrl[i*DW +: DW] == m_ctrl[i], (wr_en && s < 0) ? "R9" : "R2",
                  "ch_ctrl", ch_ctrl[i*DW +: DW], m_ctrl[i]);
        wr_en = 0; rd_en = 0; glb_ev = '0; ch_ev = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1; step();
    endtask

    task automatic rd(input logic [AW-1:0] a);
        addr = a; rd_en = 1; step();
    endtask

    task automatic idle();
        step();
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i <= NCH; i++) begin
            m_ctrl[i] = '0; m_mask[i] = '0; m_isr[i] = '0;
        end
        m_rdata = '0;
        repeat (3) @(negedge clk);
        check(rdata == 0, "R1", "rdata", rdata, 0);
        check(irq_n == 1, "R1", "irq_n", irq_n, 1);
        check(glb_ctrl == 0, "R1", "glb_ctrl", glb_ctrl, 0);
        check(ch_ctrl == 0, "R1", "ch_ctrl", ch_ctrl, 0);
        rst_n = 1;
        rd(10'h222);
        check(rdata == 0, "R1", "isr after reset", rdata, 0);
        rd(10'h323);
        check(rdata == 0, "R1", "mask after reset", rdata, 0);

        // R8 decode
        wr(10'h120, 8'hA5);
        wr(10'h000, 8'h3C);
        wr(10'h020, 8'h5A);
        check(ch_ctrl[15:8] == 8'hA5, "R8", "ch1 ctrl", ch_ctrl[15:8], 8'hA5);
        check(glb_ctrl == 8'h3C, "R8", "global ctrl", glb_ctrl, 8'h3C);
        check(ch_ctrl[7:0] == 8'h5A, "R8", "ch0 ctrl", ch_ctrl[7:0], 8'h5A);
        rd(10'h120);
        check(rdata == 8'hA5, "R8", "ch1 ctrl read", rdata, 8'hA5);

        // R9 unmapped
        wr(10'h005, 8'hFF);
        wr(10'h015, 8'hFF);
        wr(10'h124, 8'hFF);
        check(ch_ctrl == 32'h0000A55A, "R9", "ch ctrl after unmapped wr", ch_ctrl, 32'h0000A55A);
        check(glb_ctrl == 8'h3C, "R9", "glb ctrl after unmapped wr", glb_ctrl, 8'h3C);
        rd(10'h005);
        check(rdata == 0, "R9", "unmapped read", rdata, 0);

        // R3 status read-only and live
        ch_st[7:0] = 8'h11;
        wr(10'h021, 8'hFF);
        rd(10'h021);
        check(rdata == 8'h11, "R3", "status live", rdata, 8'h11);

        // R4 sticky, R5 clear on read
        ch_ev[2*DW +: DW] = 8'h08; idle();
        idle(); idle();
        check(irq_n == 0, "R7", "pending irq", irq_n, 0);
        wr(10'h222, 8'h00);
        rd(10'h222);
        check(rdata == 8'h08, "R4", "sticky isr", rdata, 8'h08);
        rd(10'h222);
        check(rdata == 8'h00, "R5", "cleared isr", rdata, 8'h00);

        // R6 event during read
        addr = 10'h322; rd_en = 1; ch_ev[3*DW +: DW] = 8'h01; step();
        check(rdata == 8'h00, "R6", "read returns pre-edge", rdata, 8'h00);
        rd(10'h322);
        check(rdata == 8'h01, "R6", "event kept", rdata, 8'h01);

        // R7 mask
        glb_ev = 8'h80; idle();
        check(irq_n == 0, "R7", "unmasked", irq_n, 0);
        wr(10'h003, 8'h80);
        check(irq_n == 1, "R7", "masked", irq_n, 1);
        wr(10'h003, 8'h00);
        check(irq_n == 0, "R7", "unmasked again", irq_n, 0);
        rd(10'h002);
        check(irq_n == 1, "R7", "cleared", irq_n, 1);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] up = 2'($urandom);
            case ($urandom % 4)
                0: addr = {up, 8'(CBASE + ($urandom % 4))};
                1: addr = {2'b00, 8'($urandom % 4)};
                2: addr = 10'($urandom);
                default: addr = {up, 8'($urandom % 48)};
            endcase
            wdata = 8'($urandom);
            wr_en = ($urandom % 3) == 0;
            rd_en = ($urandom % 2) == 0;
            glb_st = 8'($urandom);
            ch_st = $urandom;
            if ($urandom % 4 == 0) begin
                glb_ev = 8'($urandom & $urandom & $urandom);
                ch_ev = $urandom & $urandom & $urandom;
            end
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule